// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the control core of a slow, high-resolution delta-sigma converter. It moves the converter between a power-on wake-up phase, an idle standby state, a two-phase calibration (zero point first, then full-scale slope) and a conversion state. It works from the master clock, but every decision is taken at half that rate. Wake-up, calibration and conversion all last a parameterised number of master clocks.

The converter is controlled by four levels: a calibrate request, a convert request, a channel select and a polarity select. A rising convert request starts a conversion and captures the channel and polarity bits. While convert stays high, conversions follow one another back to back. Convert and calibrate held high together start a calibration.

At the end of each conversion the block pulses an update strobe for one master clock. With that strobe it presents the result word handed in by the filter model, together with the channel and polarity captured at the start of the conversion. The modulator, the filter arithmetic and the calibration arithmetic are outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the state code is 0 (wake-up), the update strobe is low, and the word, channel and polarity outputs are 0. State codes are: 0 wake-up, 1 standby, 2 offset calibration, 3 gain calibration, 4 conversion.
- R2: Wake-up ends exactly 1800 master clocks after reset falls. If no command is present at that point, the state becomes standby (1).
- R3: Command levels present during wake-up are acted on only when wake-up ends. Calibrate and convert both high give offset calibration. Convert high alone gives a conversion that uses the channel and polarity levels present at that moment.
- R4: Outside wake-up and calibration, calibrate and convert both high start offset calibration (2). This takes priority over conversion and abandons a conversion in progress without an update. Offset calibration lasts 1624 master clocks, gain calibration (3) lasts another 1624, and then the state returns to standby (1).
- R5: A convert rising edge seen in standby enters conversion (4) within two master clocks. The channel and polarity inputs are captured at that moment.
- R6: The update strobe is high for one master clock, 1624 master clocks after a conversion starts. In the same cycle the outputs show the result input sampled at the update edge and the captured channel and polarity.
- R7: While convert remains high, every further update follows the previous one after exactly 1622 master clocks. If convert is low at an update, the state returns to standby.
- R8: A convert rising edge during a conversion abandons it, recaptures channel and polarity, and restarts the full 1624-clock count.
- R9: Channel and polarity changes after a conversion starts do not alter the reported values. Convert edges during calibration are ignored.
- R10: All state changes fall on alternate master clock edges, so the state never changes on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cal_i | input | 1 | Calibrate request level |
| conv_i | input | 1 | Convert request level |
| chan_i | input | 1 | Channel select |
| bip_i | input | 1 | Polarity select (1 bipolar) |
| result_i | input | WORD_W | Result word from the filter model |
| state_o | output | 3 | Current state code |
| upd_o | output | 1 | One-clock update strobe |
| word_o | output | WORD_W | Result word latched at update |
| chan_o | output | 1 | Channel of the latched word |
| bip_o | output | 1 | Polarity of the latched word |

## Verification
The checker watches several properties on every cycle. The state stays in wake-up for the full wake-up window and leaves it exactly when the window ends. Offset calibration always hands over to gain calibration, and gain calibration always returns to standby. An update only follows a cycle spent converting, the strobe never lasts two cycles, the reported tags change only with an update, and state changes never fall on consecutive clocks. Other behaviours depend on the stimulus that led up to them, and only the bench scenarios can show those: the exact conversion and back-to-back periods, restart on a new edge, abandonment by a calibration request, deferred power-on commands, and the channel captured at the start rather than at the update.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      ST_WAKE    = 3'd0,
      ST_STBY    = 3'd1,
      ST_OFFCAL  = 3'd2,
      ST_GAINCAL = 3'd3,
      ST_CONV    = 3'd4
   } seq_state_t;
endpackage

// File: rtl/adc_seq_phase.sv
// Half-rate tick: high on every second master clock edge after reset.
module adc_seq_phase (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   logic ph_q;
   always_ff @(posedge clk) begin
      if (rst) ph_q <= 1'b0;
      else     ph_q <= ~ph_q;
   end
   assign tick_o = ph_q;
endmodule

// File: rtl/adc_seq_timer.sv
// Tick counter: done when the running count reaches limit-1 ticks.
module adc_seq_timer #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_i,
   input  logic          run_i,
   input  logic          restart_i,
   input  logic [CW-1:0] limit_i,
   output logic          done_o
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
   logic [CW-1:0] cnt_q;
   always_ff @(posedge clk) begin
      if (rst)                     cnt_q <= '0;
      else if (tick_i && restart_i) cnt_q <= '0;
      else if (tick_i && run_i)    cnt_q <= cnt_q + ONE;
   end
   assign done_o = (cnt_q == (limit_i - ONE));
endmodule

// File: rtl/adc_seq_port.sv
// Output holding register, loaded by the update strobe.
module adc_seq_port #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              chan_i,
   input  logic              bip_i,
   output logic              upd_o,
   output logic [WORD_W-1:0] word_o,
   output logic              chan_o,
   output logic              bip_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         upd_o  <= 1'b0;
         word_o <= '0;
         chan_o <= 1'b0;
         bip_o  <= 1'b0;
      end else begin
         upd_o <= fire_i;
         if (fire_i) begin
            word_o <= word_i;
            chan_o <= chan_i;
            bip_o  <= bip_i;
         end
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int WORD_W   = 20,
   parameter int WAKE_CYC = 1800,
   parameter int CONV_CYC = 1624,
   parameter int CONT_CYC = 1622,
   parameter int CAL_CYC  = 1624
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cal_i,
   input  logic              conv_i,
   input  logic              chan_i,
   input  logic              bip_i,
   input  logic [WORD_W-1:0] result_i,
   output logic [2:0]        state_o,
   output logic              upd_o,
   output logic [WORD_W-1:0] word_o,
   output logic              chan_o,
   output logic              bip_o
);
   localparam int WAKE_T = WAKE_CYC / 2;
   localparam int CONV_T = CONV_CYC / 2;
   localparam int CONT_T = CONT_CYC / 2;
   localparam int CAL_T  = CAL_CYC / 2;
   localparam int MAX_T  = (WAKE_T > CONV_T ? WAKE_T : CONV_T) > CAL_T ?
                           (WAKE_T > CONV_T ? WAKE_T : CONV_T) : CAL_T;
   localparam int CW     = $clog2(MAX_T + 1) + 1;

   generate
      if ((WAKE_CYC % 2) != 0 || (CONV_CYC % 2) != 0 ||
          (CONT_CYC % 2) != 0 || (CAL_CYC % 2) != 0) begin : g_odd_period
         $error("adc_seq_ctrl: all periods must be even master-clock counts");
      end
      if (WAKE_CYC < 4 || CONV_CYC < 4 || CONT_CYC < 4 || CAL_CYC < 4) begin : g_short_period
         $error("adc_seq_ctrl: periods must be at least 4 clocks");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("adc_seq_ctrl: WORD_W must be positive");
      end
   endgenerate

   logic       tick;
   logic       done;
   logic       restart;
   logic       latch;
   logic       fire;
   logic       first_q, first_n;
   logic       conv_q;
   logic       chan_lat, bip_lat;
   logic       both, rise;
   logic [CW-1:0] limit;
   seq_state_t st_q, st_n;

   adc_seq_phase u_phase (.clk(clk), .rst(rst), .tick_o(tick));

   always_comb begin
      unique case (st_q)
         ST_WAKE:               limit = CW'(WAKE_T);
         ST_OFFCAL, ST_GAINCAL: limit = CW'(CAL_T);
         default:               limit = first_q ? CW'(CONV_T) : CW'(CONT_T);
      endcase
   end

   adc_seq_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst(rst), .tick_i(tick), .run_i(st_q != ST_STBY),
      .restart_i(restart), .limit_i(limit), .done_o(done)
   );

   assign both = cal_i & conv_i;
   assign rise = conv_i & ~conv_q;

   always_comb begin
      st_n    = st_q;
      first_n = first_q;
      restart = 1'b0;
      latch   = 1'b0;
      fire    = 1'b0;
      if (tick) begin
         if (st_q == ST_WAKE) begin
            if (done) begin
               if (both) begin
                  st_n = ST_OFFCAL; restart = 1'b1;
               end else if (conv_i) begin
                  st_n = ST_CONV; restart = 1'b1; latch = 1'b1; first_n = 1'b1;
               end else begin
                  st_n = ST_STBY;
               end
            end
         end else if (both && st_q != ST_OFFCAL && st_q != ST_GAINCAL) begin
            st_n = ST_OFFCAL; restart = 1'b1;
         end else begin
            unique case (st_q)
               ST_STBY: if (rise) begin
                  st_n = ST_CONV; restart = 1'b1; latch = 1'b1; first_n = 1'b1;
               end
               ST_OFFCAL: if (done) begin
                  st_n = ST_GAINCAL; restart = 1'b1;
               end
               ST_GAINCAL: if (done) st_n = ST_STBY;
               ST_CONV: begin
                  if (rise) begin
                     restart = 1'b1; latch = 1'b1; first_n = 1'b1;
                  end else if (done) begin
                     fire = 1'b1;
                     if (conv_i) begin
                        restart = 1'b1; first_n = 1'b0;
                     end else begin
                        st_n = ST_STBY;
                     end
                  end
               end
               default: st_n = st_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_WAKE;
         first_q  <= 1'b1;
         conv_q   <= 1'b0;
         chan_lat <= 1'b0;
         bip_lat  <= 1'b0;
      end else begin
         st_q    <= st_n;
         first_q <= first_n;
         if (tick) conv_q <= conv_i;
         if (latch) begin
            chan_lat <= chan_i;
            bip_lat  <= bip_i;
         end
      end
   end

   adc_seq_port #(.WORD_W(WORD_W)) u_port (
      .clk(clk), .rst(rst), .fire_i(fire), .word_i(result_i),
      .chan_i(chan_lat), .bip_i(bip_lat),
      .upd_o(upd_o), .word_o(word_o), .chan_o(chan_o), .bip_o(bip_o)
   );

   assign state_o = st_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int WAKE_CYC = 1800
) (
   input logic       clk,
   input logic       rst,
   input logic [2:0] state_o,
   input logic       upd_o,
   input logic       chan_o,
   input logic       bip_o
);
   logic [31:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst <= 32'(WAKE_CYC)) since_rst <= since_rst + 32'd1;
   end

   AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (since_rst < 32'(WAKE_CYC)) |-> (state_o == 3'd0)); // R2
   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 32'(WAKE_CYC)) |-> (state_o != 3'd0)); // R2
   AST_OFFCAL_TO_GAIN: assert property (@(posedge clk) disable iff (rst)
      ($past(state_o) == 3'd2 && state_o != 3'd2) |-> (state_o == 3'd3)); // R4
   AST_GAIN_TO_STBY: assert property (@(posedge clk) disable iff (rst)
      ($past(state_o) == 3'd3 && state_o != 3'd3) |-> (state_o == 3'd1)); // R4
   AST_UPD_FROM_CONV: assert property (@(posedge clk) disable iff (rst)
      upd_o |-> ($past(state_o) == 3'd4)); // R6
   AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      upd_o |=> !upd_o); // R6
   AST_TAG_ON_UPD: assert property (@(posedge clk) disable iff (rst)
      ({chan_o, bip_o} != $past({chan_o, bip_o})) |-> upd_o); // R9
   AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
      (state_o != $past(state_o)) |=> $stable(state_o)); // R10
   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
      state_o <= 3'd4); // R1
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
   .clk(clk), .rst(rst), .state_o(state_o), .upd_o(upd_o),
   .chan_o(chan_o), .bip_o(bip_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
   localparam int W     = 20;
   localparam int WAKE  = 1800;
   localparam int CONVC = 1624;
   localparam int CONTC = 1622;
   localparam int CALC  = 1624;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cal = 1'b0, conv = 1'b0, chan = 1'b0, bip = 1'b0;
   logic [W-1:0] result = '0;
   logic [2:0]   state_o;
   logic         upd_o, chan_o, bip_o;
   logic [W-1:0] word_o;

   always #2.5 clk = ~clk;

   adc_seq_ctrl #(.WORD_W(W), .WAKE_CYC(WAKE), .CONV_CYC(CONVC),
                  .CONT_CYC(CONTC), .CAL_CYC(CALC)) dut_i (
      .clk(clk), .rst(rst), .cal_i(cal), .conv_i(conv), .chan_i(chan),
      .bip_i(bip), .result_i(result), .state_o(state_o), .upd_o(upd_o),
      .word_o(word_o), .chan_o(chan_o), .bip_o(bip_o)
   );

   int compared = 0, mismatched = 0, cyc = 0, upd_seen = 0;
   bit finished = 0;
   string cur_req = "R1";

   // behavioural reference: edge number since reset, phase start edge and span
   int m_n, m_start, m_span, m_st;
   bit m_pconv, m_upd, m_chan, m_bip, m_lc, m_lb;
   logic [W-1:0] m_word;

   always @(posedge clk) begin
      cyc++;
      result <= result;
      if (rst) begin
         m_n = 0; m_start = 0; m_span = WAKE; m_st = 0; m_pconv = 0;
         m_upd = 0; m_word = '0; m_chan = 0; m_bip = 0; m_lc = 0; m_lb = 0;
      end else begin
         bit both, rise, fin;
         m_n++;
         m_upd = 0;
         if (m_n % 2 == 0) begin
            both = cal && conv;
            rise = conv && !m_pconv;
            fin  = (m_st != 1) && (m_n - m_start == m_span);
            if (m_st == 0) begin
               if (fin) begin
                  if (both) begin m_st = 2; m_start = m_n; m_span = CALC; end
                  else if (conv) begin
                     m_st = 4; m_start = m_n; m_span = CONVC; m_lc = chan; m_lb = bip;
                  end else m_st = 1;
               end
            end else if (both && m_st != 2 && m_st != 3) begin
               m_st = 2; m_start = m_n; m_span = CALC;
            end else if (m_st == 1 && rise) begin
               m_st = 4; m_start = m_n; m_span = CONVC; m_lc = chan; m_lb = bip;
            end else if (m_st == 2 && fin) begin
               m_st = 3; m_start = m_n; m_span = CALC;
            end else if (m_st == 3 && fin) begin
               m_st = 1;
            end else if (m_st == 4) begin
               if (rise) begin
                  m_start = m_n; m_span = CONVC; m_lc = chan; m_lb = bip;
               end else if (fin) begin
                  m_upd = 1; m_word = result; m_chan = m_lc; m_bip = m_lb;
                  if (conv) begin m_start = m_n; m_span = CONTC; end
                  else m_st = 1;
               end
            end
            m_pconv = conv;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst && !finished) begin
         compared++;
         if (state_o !== 3'(m_st) || upd_o !== m_upd || word_o !== m_word ||
             chan_o !== m_chan || bip_o !== m_bip) begin
            mismatched++;
            $display("FAIL %s cyc %0d: act st=%0d upd=%0b w=%h c=%0b b=%0b exp st=%0d upd=%0b w=%h c=%0b b=%0b",
                     cur_req, cyc, state_o, upd_o, word_o, chan_o, bip_o,
                     m_st, m_upd, m_word, m_chan, m_bip);
         end
         if (upd_o) upd_seen++;
         result <= result + 20'h1F3A7;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic negs(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic wait_state(input int s);
      @(negedge clk);
      while (state_o != 3'(s)) @(negedge clk);
   endtask

   task automatic wait_upd();
      @(negedge clk);
      while (!upd_o) @(negedge clk);
   endtask

   task automatic do_reset(input bit c, input bit v, input bit ch, input bit bp);
      @(negedge clk);
      rst = 1; cal = c; conv = v; chan = ch; bip = bp;
      negs(3);
      rst = 0;
   endtask

   initial begin : watchdog
      wait (cyc >= 150000);
      if (!finished) begin
         finished = 1;
         mismatched++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      int t0, t1, t2, u0;
      negs(2);
      // R1 reset values
      chk(state_o == 3'd0 && !upd_o && word_o == '0 && !chan_o && !bip_o,
          "R1", "state during reset", state_o, 0);
      do_reset(0, 0, 0, 0);
      @(negedge clk);
      chk(state_o == 3'd0 && !upd_o, "R1", "state after release", state_o, 0);
      // R2 wake-up window
      cur_req = "R2";
      while (m_n < WAKE - 1) @(negedge clk);
      chk(state_o == 3'd0, "R2", "state at clock 1799", state_o, 0);
      @(negedge clk);
      chk(state_o == 3'd1, "R2", "state at clock 1800", state_o, 1);

      // R4 and R9: calibration sequence, convert edges ignored inside it
      cur_req = "R4";
      negs(5);
      cal = 1; conv = 1;
      wait_state(2); t0 = cyc;
      cal = 0; conv = 0;
      u0 = upd_seen;
      for (int i = 0; i < 6; i++) begin negs(7); conv = ~conv; end
      conv = 0;
      cur_req = "R9";
      chk(state_o == 3'd2, "R9", "state after convert edges in calibration", state_o, 2);
      wait_state(3); t1 = cyc;
      chk(t1 - t0 == CALC, "R4", "offset calibration length", t1 - t0, CALC);
      wait_state(1); t2 = cyc;
      chk(t2 - t1 == CALC, "R4", "gain calibration length", t2 - t1, CALC);
      chk(upd_seen == u0, "R9", "updates during calibration", upd_seen - u0, 0);

      // R5 R6 R7: conversion start, tag capture, back-to-back period
      cur_req = "R6";
      negs(4);
      chan = 1; bip = 1; conv = 1; t0 = cyc;
      negs(3);
      chk(state_o == 3'd4, "R5", "state two clocks after convert rise", state_o, 4);
      chan = 0; bip = 0;
      wait_upd(); t1 = cyc;
      chk(t1 - t0 >= CONVC + 1 && t1 - t0 <= CONVC + 2, "R6", "first update delay",
          t1 - t0, CONVC + 1);
      chk(chan_o && bip_o, "R9", "tags held from conversion start", {chan_o, bip_o}, 3);
      cur_req = "R7";
      wait_upd(); t2 = cyc;
      chk(t2 - t1 == CONTC, "R7", "back-to-back update period", t2 - t1, CONTC);
      conv = 0;
      wait_upd();
      negs(2);
      chk(state_o == 3'd1, "R7", "standby after final update", state_o, 1);

      // R8: restart on a new convert edge
      cur_req = "R8";
      chan = 0; bip = 1; conv = 1;
      negs(500);
      conv = 0; negs(4);
      chan = 1; bip = 0; conv = 1; t0 = cyc;
      wait_upd(); t1 = cyc;
      chk(t1 - t0 >= CONVC + 1 && t1 - t0 <= CONVC + 2, "R8", "update delay after restart",
          t1 - t0, CONVC + 1);
      chk(chan_o && !bip_o, "R8", "tags from restart edge", {chan_o, bip_o}, 2);

      // R4: calibration request abandons a conversion
      cur_req = "R4";
      negs(300);
      u0 = upd_seen;
      cal = 1; negs(3);
      chk(state_o == 3'd2, "R4", "calibration preempts conversion", state_o, 2);
      cal = 0; conv = 0;
      wait_state(1);
      chk(upd_seen == u0, "R4", "no update from abandoned conversion", upd_seen - u0, 0);

      // R3: commands present during wake-up
      cur_req = "R3";
      do_reset(1, 1, 0, 0);
      while (m_n < WAKE) @(negedge clk);
      chk(state_o == 3'd2, "R3", "calibration after wake-up", state_o, 2);
      cal = 0; conv = 0;
      wait_state(1);
      do_reset(0, 1, 1, 0);
      while (m_n < WAKE) @(negedge clk);
      chk(state_o == 3'd4, "R3", "conversion after wake-up", state_o, 4);
      conv = 0;
      wait_upd();
      chk(chan_o && !bip_o, "R3", "channel from wake-up level", {chan_o, bip_o}, 2);
      negs(4);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule